// File: doc/BRIEF.md
# Sound Register Decode and Status

This block sits between a processor bus and the channel logic of a four-voice sound generator with a sample-playback voice. It watches a 32-byte address window. A write inside the window that lands on a channel register becomes a one-cycle, registered strobe on its own output line, and the write data is carried alongside it. A write to any other address, inside the window or outside it, is passed to an expansion port together with its address and data.

The block holds three pieces of shared state: the voice enable bits, the frame interrupt flag and the playback interrupt flag. A read of the status register gathers these into one byte. It combines the four length-activity indications, the "bytes remaining" indication from the playback voice, and both interrupt flags. The data appears in the same cycle as the read strobe, and the read clears the frame flag. A write to the status register loads the enables and clears the playback flag. The interrupt output is the OR of both flags and an external interrupt input.

Top module: `snd_regif`

## Requirements
- R1: Writes to window offsets 0x00–0x07 pulse strobes 0–7 (first pulse voice: control, sweep, timer low, timer high at strobes 0–3; second pulse voice in the same order at strobes 4–7).
- R2: Writes to offsets 0x08, 0x0A and 0x0B pulse strobes 8, 9 and 10 (triangle). Writes to offsets 0x0C, 0x0E and 0x0F pulse strobes 11, 12 and 13 (noise).
- R3: Writes to offsets 0x10–0x13 pulse strobes 14–17 (playback control, level, start address, length). A write to offset 0x17 pulses strobe 18 (frame sequencer control).
- R4: A write to any address that R1–R3 and R7 do not map pulses `ext_wr`, with `ext_addr` and `wr_data` carrying that write. This includes offsets 0x09, 0x0D, 0x14, 0x16 and 0x18–0x1F, and all addresses outside the window. Such a write pulses no channel strobe.
- R5: While `bus_re` is high at offset 0x15, `rd_data` shows the following bits. Bits 0–3 carry `len_active[3:0]`. Bit 4 carries `play_bytes_left`. Bit 5 is 0.
- R6: Status read bit 6 is the frame interrupt flag. A pulse on `frame_irq_set` sets the flag, and it reads as 1 from the next cycle. A status read clears the flag after the read cycle.
- R7: A write to offset 0x15 loads `chan_en[4:0]` from data bits 4–0 and clears the playback interrupt flag. It produces no strobe and no `ext_wr`.
- R8: `irq` is high whenever the frame flag, the playback flag or `ext_irq_in` is high.
- R9: A write to offset 0x17 with data bit 6 set clears the frame flag. With data bit 6 clear, the write leaves the flag unchanged.
- R10: A set pulse wins over a clear in the same cycle, for both interrupt flags.
- R11: Status read bit 7 is the playback flag, which `play_irq_set` sets. A read at any other address returns 0 and does not clear the frame flag. No read clears the playback flag.
- R12: Each strobe and `ext_wr` is high for exactly the cycle after its write. At most one of them is high at a time. Back-to-back writes give back-to-back strobes.
- R13: After reset, all strobes, `ext_wr`, `chan_en` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| len_active | input | 4 | Length counter nonzero: pulse 1, pulse 2, triangle, noise |
| play_bytes_left | input | 1 | Playback voice has bytes remaining |
| frame_irq_set | input | 1 | Frame sequencer interrupt event |
| play_irq_set | input | 1 | Playback voice interrupt event |
| ext_irq_in | input | 1 | Expansion interrupt request |
| wr_strobe | output | 19 | One-hot registered register-write strobes |
| wr_data | output | 8 | Registered write data accompanying any strobe |
| chan_en | output | 5 | Voice enables: pulse 1, pulse 2, triangle, noise, playback |
| ext_wr | output | 1 | Registered expansion write strobe |
| ext_addr | output | 16 | Address accompanying `ext_wr` |
| rd_data | output | 8 | Status read data, same cycle as `bus_re` |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is the coincidence of a flag's set event with its clearing access in the same cycle. The frame event must meet a status read, or a control write with bit 6 set. The playback event must meet a status write. The stimulus raises the event input on the same falling edge that presents the read or write, so both land on one rising edge. It then reads the status back to see which side won. Unmapped holes inside the window are also driven on purpose, along with back-to-back writes that must not merge.

// File: rtl/snd_regif_pkg.sv
`timescale 1ns/1ps
package snd_regif_pkg;

  localparam int NUM_STROBES = 19;
  localparam int OFS_W       = 5;
  localparam int SEL_W       = 5;

  // Status byte bit positions that the processor decodes.
  localparam int ST_FRAME_BIT = 6;
  localparam int ST_PLAY_BIT  = 7;
  localparam int EN_INHIBIT_BIT = 6;  // frame control: interrupt inhibit

  localparam logic [OFS_W-1:0] OFS_STATUS = 5'h15;

  typedef enum logic [SEL_W-1:0] {
    SEL_SQA_CTL = 5'd0,  SEL_SQA_SWP = 5'd1,  SEL_SQA_TLO = 5'd2,  SEL_SQA_THI = 5'd3,
    SEL_SQB_CTL = 5'd4,  SEL_SQB_SWP = 5'd5,  SEL_SQB_TLO = 5'd6,  SEL_SQB_THI = 5'd7,
    SEL_TRI_LIN = 5'd8,  SEL_TRI_TLO = 5'd9,  SEL_TRI_THI = 5'd10,
    SEL_NZ_CTL  = 5'd11, SEL_NZ_PER  = 5'd12, SEL_NZ_LEN  = 5'd13,
    SEL_PB_CTL  = 5'd14, SEL_PB_LVL  = 5'd15, SEL_PB_ADR  = 5'd16, SEL_PB_LEN = 5'd17,
    SEL_FRM_CTL = 5'd18
  } reg_sel_e;

  typedef struct packed {
    logic     hit;     // channel register
    reg_sel_e sel;
    logic     status;  // status register
  } decode_t;

  function automatic decode_t map_offset(input logic [OFS_W-1:0] ofs);
    decode_t d;
    d.hit    = 1'b1;
    d.status = 1'b0;
    d.sel    = SEL_SQA_CTL;
    case (ofs)
      5'h00: d.sel = SEL_SQA_CTL;
      5'h01: d.sel = SEL_SQA_SWP;
      5'h02: d.sel = SEL_SQA_TLO;
      5'h03: d.sel = SEL_SQA_THI;
      5'h04: d.sel = SEL_SQB_CTL;
      5'h05: d.sel = SEL_SQB_SWP;
      5'h06: d.sel = SEL_SQB_TLO;
      5'h07: d.sel = SEL_SQB_THI;
      5'h08: d.sel = SEL_TRI_LIN;
      5'h0A: d.sel = SEL_TRI_TLO;
      5'h0B: d.sel = SEL_TRI_THI;
      5'h0C: d.sel = SEL_NZ_CTL;
      5'h0E: d.sel = SEL_NZ_PER;
      5'h0F: d.sel = SEL_NZ_LEN;
      5'h10: d.sel = SEL_PB_CTL;
      5'h11: d.sel = SEL_PB_LVL;
      5'h12: d.sel = SEL_PB_ADR;
      5'h13: d.sel = SEL_PB_LEN;
      5'h17: d.sel = SEL_FRM_CTL;
      5'h15: begin
        d.hit    = 1'b0;
        d.status = 1'b1;
      end
      default: d.hit = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/snd_addr_decode.sv
`timescale 1ns/1ps
module snd_addr_decode
  import snd_regif_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              dec_hit,
  output reg_sel_e          dec_sel,
  output logic              dec_status,
  output logic              dec_ext
);

  localparam int HI_W = ADDR_W - OFS_W;

  logic    in_window;
  decode_t raw;

  assign in_window = (addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);

  always_comb begin
    raw        = map_offset(addr[OFS_W-1:0]);
    dec_hit    = in_window && raw.hit;
    dec_status = in_window && raw.status;
    dec_sel    = raw.sel;
    dec_ext    = !(dec_hit || dec_status);
  end

  // Decoded classes are mutually exclusive.
  always_comb begin
    a_r4_class_exclusive: assert ($countones({dec_hit, dec_status, dec_ext}) == 1 || $isunknown(addr));
  end

  if (HI_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed window width");
  end

endmodule

// File: rtl/snd_strobe_gen.sv
`timescale 1ns/1ps
module snd_strobe_gen
  import snd_regif_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic                   dec_hit,
  input  reg_sel_e               dec_sel,
  input  logic                   dec_ext,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [NUM_STROBES-1:0] wr_strobe,
  output logic [DATA_W-1:0]      wr_data,
  output logic                   ext_wr,
  output logic [ADDR_W-1:0]      ext_addr
);

  for (genvar i = 0; i < NUM_STROBES; i++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (rst) wr_strobe[i] <= 1'b0;
      else     wr_strobe[i] <= we && dec_hit && (dec_sel == reg_sel_e'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_wr   <= 1'b0;
      ext_addr <= '0;
      wr_data  <= '0;
    end else begin
      ext_wr <= we && dec_ext;
      if (we) begin
        ext_addr <= addr;
        wr_data  <= wdata;
      end
    end
  end

  // R12: at most one strobe of any kind per cycle
  a_r12_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_strobe, ext_wr}));

  // R12: no strobe the cycle after an idle bus
  a_r12_single_cycle: assert property (@(posedge clk) disable iff (rst)
    !we |=> (wr_strobe == '0 && !ext_wr));

  // R4: unmapped write forwarded with its address
  a_r4_ext_fwd: assert property (@(posedge clk) disable iff (rst)
    (we && dec_ext) |=> (ext_wr && ext_addr == $past(addr) && wr_data == $past(wdata)));

endmodule

// File: rtl/snd_status_unit.sv
`timescale 1ns/1ps
module snd_status_unit
  import snd_regif_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_LEN = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic               re,
  input  logic               is_status,
  input  logic               is_frame_ctl,
  input  logic [NUM_LEN:0]   en_bits,
  input  logic               inhibit_bit,
  input  logic [NUM_LEN-1:0] len_active,
  input  logic               bytes_left,
  input  logic               frame_irq_set,
  input  logic               play_irq_set,
  input  logic               ext_irq,
  output logic [NUM_LEN:0]   chan_en,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq
);

  localparam int EN_W = NUM_LEN + 1;

  logic frame_q, play_q;
  logic frame_clr, play_clr, status_wr;

  assign status_wr = we && is_status;
  assign frame_clr = (re && is_status) || (we && is_frame_ctl && inhibit_bit);
  assign play_clr  = status_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= 1'b0;
      play_q  <= 1'b0;
      chan_en <= '0;
    end else begin
      // Set has priority so that no event is lost.
      if (frame_irq_set)  frame_q <= 1'b1;
      else if (frame_clr) frame_q <= 1'b0;
      if (play_irq_set)   play_q  <= 1'b1;
      else if (play_clr)  play_q  <= 1'b0;
      if (status_wr)      chan_en <= en_bits[EN_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (re && is_status) begin
      for (int b = 0; b < NUM_LEN; b++) rd_data[b] = len_active[b];
      rd_data[NUM_LEN]      = bytes_left;
      rd_data[ST_FRAME_BIT] = frame_q;
      rd_data[ST_PLAY_BIT]  = play_q;
    end
  end

  assign irq = frame_q || play_q || ext_irq;

  // R6: a status read without a set event clears the frame flag
  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (re && is_status && !frame_irq_set) |=> !rd_frame_peek());

  // R7: a status write loads the enables
  a_r7_enable_load: assert property (@(posedge clk) disable iff (rst)
    status_wr |=> (chan_en == $past(en_bits)));

  // R7: a status write without a set event clears the playback flag
  a_r7_play_clear: assert property (@(posedge clk) disable iff (rst)
    (status_wr && !play_irq_set) |=> !irq_play_peek());

  // R10: set events always leave the flag high
  a_r10_frame_set_wins: assert property (@(posedge clk) disable iff (rst)
    frame_irq_set |=> irq);
  a_r10_play_set_wins: assert property (@(posedge clk) disable iff (rst)
    play_irq_set |=> irq);

  // R5: bit 5 of any read is zero
  always_comb begin
    a_r5_bit5_zero: assert (rd_data[5] == 1'b0);
  end

  function automatic logic rd_frame_peek();
    return frame_q;
  endfunction

  function automatic logic irq_play_peek();
    return play_q;
  endfunction

endmodule

// File: rtl/snd_regif.sv
`timescale 1ns/1ps
module snd_regif
  import snd_regif_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter int              NUM_LEN   = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  input  logic                   bus_we,
  input  logic                   bus_re,
  input  logic [NUM_LEN-1:0]     len_active,
  input  logic                   play_bytes_left,
  input  logic                   frame_irq_set,
  input  logic                   play_irq_set,
  input  logic                   ext_irq_in,
  output logic [NUM_STROBES-1:0] wr_strobe,
  output logic [DATA_W-1:0]      wr_data,
  output logic [NUM_LEN:0]       chan_en,
  output logic                   ext_wr,
  output logic [ADDR_W-1:0]      ext_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   irq
);

  logic     dec_hit, dec_status, dec_ext;
  reg_sel_e dec_sel;
  logic     is_frame_ctl;

  snd_addr_decode #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr      (bus_addr),
    .dec_hit   (dec_hit),
    .dec_sel   (dec_sel),
    .dec_status(dec_status),
    .dec_ext   (dec_ext)
  );

  assign is_frame_ctl = dec_hit && (dec_sel == SEL_FRM_CTL);

  snd_strobe_gen #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_stb (
    .clk      (clk),
    .rst      (rst),
    .we       (bus_we),
    .dec_hit  (dec_hit),
    .dec_sel  (dec_sel),
    .dec_ext  (dec_ext),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .wr_strobe(wr_strobe),
    .wr_data  (wr_data),
    .ext_wr   (ext_wr),
    .ext_addr (ext_addr)
  );

  snd_status_unit #(
    .DATA_W (DATA_W),
    .NUM_LEN(NUM_LEN)
  ) u_sts (
    .clk          (clk),
    .rst          (rst),
    .we           (bus_we),
    .re           (bus_re),
    .is_status    (dec_status),
    .is_frame_ctl (is_frame_ctl),
    .en_bits      (bus_wdata[NUM_LEN:0]),
    .inhibit_bit  (bus_wdata[EN_INHIBIT_BIT]),
    .len_active   (len_active),
    .bytes_left   (play_bytes_left),
    .frame_irq_set(frame_irq_set),
    .play_irq_set (play_irq_set),
    .ext_irq      (ext_irq_in),
    .chan_en      (chan_en),
    .rd_data      (rd_data),
    .irq          (irq)
  );

  // R8: external request reaches the interrupt output
  a_r8_ext_irq: assert property (@(posedge clk) disable iff (rst)
    ext_irq_in |-> irq);

  // R7: a status write never produces a channel or expansion strobe
  a_r7_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (bus_we && dec_status) |=> (wr_strobe == '0 && !ext_wr));

endmodule

// File: tb/snd_regif_test.sv
`timescale 1ns/1ps
module snd_regif_test;
  import snd_regif_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we, bus_re;
  logic [3:0]  len_active;
  logic        play_bytes_left, frame_irq_set, play_irq_set, ext_irq_in;
  logic [NUM_STROBES-1:0] wr_strobe;
  logic [7:0]  wr_data;
  logic [4:0]  chan_en;
  logic        ext_wr;
  logic [15:0] ext_addr;
  logic [7:0]  rd_data;
  logic        irq;

  snd_regif uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .len_active(len_active),
    .play_bytes_left(play_bytes_left), .frame_irq_set(frame_irq_set),
    .play_irq_set(play_irq_set), .ext_irq_in(ext_irq_in),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .chan_en(chan_en),
    .ext_wr(ext_wr), .ext_addr(ext_addr), .rd_data(rd_data), .irq(irq)
  );

  typedef struct {
    logic [NUM_STROBES-1:0] vec;
    logic                   ext;
    logic [15:0]            addr;
    logic [7:0]             data;
    string                  req;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  function automatic int strobe_of(input logic [15:0] a);
    case (a)
      16'h4000: return 0;  16'h4001: return 1;  16'h4002: return 2;  16'h4003: return 3;
      16'h4004: return 4;  16'h4005: return 5;  16'h4006: return 6;  16'h4007: return 7;
      16'h4008: return 8;  16'h400A: return 9;  16'h400B: return 10;
      16'h400C: return 11; 16'h400E: return 12; 16'h400F: return 13;
      16'h4010: return 14; 16'h4011: return 15; 16'h4012: return 16; 16'h4013: return 17;
      16'h4017: return 18;
      default:  return -1;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // Driver: presents a write for one cycle and queues the expected result.
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
    exp_t e;
    int   s;
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    bus_re    = 1'b0;
    s = strobe_of(a);
    if (a != 16'h4015) begin
      e.vec  = (s >= 0) ? (NUM_STROBES'(1) << s) : '0;
      e.ext  = (s < 0);
      e.addr = a;
      e.data = d;
      e.req  = req;
      sbq.push_back(e);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    bus_we = 1'b0;
    bus_re = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] expv, input string req);
    bus_addr = a;
    bus_re   = 1'b1;
    bus_we   = 1'b0;
    #1 check(req, rd_data, expv);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  // Monitor: pops the scoreboard whenever a strobe appears.
  always @(negedge clk) begin
    if (!rst && (wr_strobe != '0 || ext_wr)) begin
      if (sbq.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R12/R7: unexpected strobe actual %h ext %b expected none", wr_strobe, ext_wr);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check({e.req, " strobe"}, 32'(wr_strobe), 32'(e.vec));
        check({e.req, " ext_wr"}, 32'(ext_wr), 32'(e.ext));
        check({e.req, " data"}, 32'(wr_data), 32'(e.data));
        if (e.ext) check({e.req, " ext_addr"}, 32'(ext_addr), 32'(e.addr));
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    len_active = '0; play_bytes_left = 1'b0;
    frame_irq_set = 1'b0; play_irq_set = 1'b0; ext_irq_in = 1'b0;
    repeat (4) @(negedge clk);
    // R13: reset state
    check("R13 strobes", 32'(wr_strobe), 0);
    check("R13 ext_wr", 32'(ext_wr), 0);
    check("R13 chan_en", 32'(chan_en), 0);
    check("R13 irq", 32'(irq), 0);
    rst = 1'b0;
    @(negedge clk);
    rd(16'h4015, 8'h00, "R13 status");

    // R1: pulse voices, back-to-back (R12)
    for (int i = 0; i < 8; i++) wr(16'h4000 + 16'(i), 8'(i * 3 + 1), "R1");
    idle(2);
    // R2: triangle and noise
    wr(16'h4008, 8'h81, "R2"); wr(16'h400A, 8'h82, "R2"); wr(16'h400B, 8'h83, "R2");
    wr(16'h400C, 8'h84, "R2"); wr(16'h400E, 8'h85, "R2"); wr(16'h400F, 8'h86, "R2");
    idle(1);
    // R3: playback and frame control (bit 6 clear)
    wr(16'h4010, 8'hA0, "R3"); wr(16'h4011, 8'hA1, "R3");
    wr(16'h4012, 8'hA2, "R3"); wr(16'h4013, 8'hA3, "R3");
    idle(1);
    wr(16'h4017, 8'h80, "R3");
    idle(2);
    // R4: unmapped addresses go to the expansion port
    wr(16'h4009, 8'h11, "R4"); wr(16'h400D, 8'h12, "R4");
    wr(16'h4014, 8'h13, "R4"); wr(16'h4016, 8'h14, "R4");
    idle(1);
    wr(16'h4018, 8'h15, "R4"); wr(16'h3FFF, 8'h16, "R4"); wr(16'h6000, 8'h17, "R4");
    idle(3);

    // R5: status activity bits
    len_active = 4'b1010; play_bytes_left = 1'b1;
    rd(16'h4015, 8'h1A, "R5");
    len_active = 4'b0101; play_bytes_left = 1'b0;
    rd(16'h4015, 8'h05, "R5");
    len_active = 4'b0000;

    // R6 / R8: frame flag set, read, cleared by the read
    frame_irq_set = 1'b1; @(negedge clk); frame_irq_set = 1'b0;
    check("R8 irq frame", 32'(irq), 1);
    rd(16'h4015, 8'h40, "R6 set");
    rd(16'h4015, 8'h00, "R6 cleared by read");
    check("R8 irq low", 32'(irq), 0);

    // R11: a read elsewhere neither returns status nor clears
    frame_irq_set = 1'b1; @(negedge clk); frame_irq_set = 1'b0;
    rd(16'h4000, 8'h00, "R11 other read");
    rd(16'h4015, 8'h40, "R11 flag kept");

    // R9: frame control write with bit 6 clear keeps, with bit 6 set clears
    frame_irq_set = 1'b1; @(negedge clk); frame_irq_set = 1'b0;
    wr(16'h4017, 8'h00, "R9 keep"); idle(1);
    check("R9 irq kept", 32'(irq), 1);
    wr(16'h4017, 8'h40, "R9 clear"); idle(1);
    check("R9 irq cleared", 32'(irq), 0);
    rd(16'h4015, 8'h00, "R9 flag clear");

    // R11 / R7: playback flag, survives reads, cleared by status write
    play_irq_set = 1'b1; @(negedge clk); play_irq_set = 1'b0;
    check("R8 irq play", 32'(irq), 1);
    rd(16'h4015, 8'h80, "R11 play flag");
    rd(16'h4015, 8'h80, "R11 play flag kept");
    wr(16'h4015, 8'h1F, "R7");
    check("R7 chan_en", 32'(chan_en), 32'h1F);
    idle(1);
    check("R7 irq cleared", 32'(irq), 0);
    rd(16'h4015, 8'h00, "R7 play flag clear");
    wr(16'h4015, 8'h0A, "R7");
    check("R7 chan_en", 32'(chan_en), 32'h0A);
    wr(16'h4015, 8'hE3, "R7");
    check("R7 chan_en upper ignored", 32'(chan_en), 32'h03);
    idle(2);

    // R8: external request
    ext_irq_in = 1'b1; #1 check("R8 ext irq", 32'(irq), 1);
    @(negedge clk); ext_irq_in = 1'b0; #1 check("R8 ext irq low", 32'(irq), 0);
    @(negedge clk);

    // R10: set coinciding with clear
    frame_irq_set = 1'b1;
    rd(16'h4015, 8'h00, "R10 read during set");
    frame_irq_set = 1'b0;
    rd(16'h4015, 8'h40, "R10 frame set wins");
    idle(1);
    play_irq_set = 1'b1;
    wr(16'h4015, 8'h00, "R10");
    play_irq_set = 1'b0;
    idle(1);
    rd(16'h4015, 8'h80, "R10 play set wins");

    idle(4);
    check("R12 scoreboard drained", 32'(sbq.size()), 0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule